// File: doc/BRIEF.md
# Log-Structured EEPROM Emulation Write Engine

This block makes a page-erasable flash array look like a small byte-addressed EEPROM for writes. Flash can only be programmed once per location between erases. Each write request is therefore appended as a 24-bit record to the active page, holding an 8-bit emulated address and a 16-bit value, and nothing is overwritten in place. The first slot of every page holds a status word with the page state and an erase/write count. That slot is never handed to a write request.

When a write fills the final slot of the active page, the engine compacts it. Only the newest value of each address is copied into the next page in rotation, in the order in which the addresses first appeared. Each copy is read back and compared. Only after all copies match does the engine program the new page's status word and erase the old page. A mismatch during compaction parks the engine in a fault state and leaves the old page untouched.

The flash array is modelled inside the block. A separate lookup unit reads it through a combinational word port and searches it backwards.

Top module: `eee_write_engine`

## Requirements
- R1: After reset the engine spends one cycle initialising with `busy` high and `wr_ready` low. After that, page 0 is active, its slot 0 reads 0x800000, and every other slot of every page reads 0xFFFFFF.
- R2: Accepted writes (`wr_valid` and `wr_ready` high at a clock edge) are stored as `{addr[23:16], data[15:0]}` in the lowest free slot of the active page, starting at slot 1. Slots not yet programmed read 0xFFFFFF, which is address 0xFF with data 0xFFFF.
- R3: A write that lands in the last slot starts compaction. From the next cycle `busy` is 1 and `wr_ready` is 0 until compaction ends. The next page (index + 1, wrapping to 0) then holds, from slot 1 upward, one record per distinct address. Each record carries the newest value of that address, and the records are ordered by first appearance. The slots after the last record stay free.
- R4: Status word layout: bits [23:22] = 2'b10 mark the page active, bits [21:16] are zero, and bits [15:0] are the erase/write count. The new page's count equals the old page's count plus one when the destination is page 0, and is unchanged otherwise.
- R5: After compaction the old page reads 0xFFFFFF in every slot and `active_page` points to the new page. `active_page` changes only in the cycle in which `busy` falls.
- R6: Writes after compaction continue in the slot right after the last packed record.
- R7: If a packed record reads back wrong, `err` rises and stays high until reset. `wr_ready` and `busy` then stay low, `active_page` does not change, further write requests are ignored, and the old page keeps all its records. While `prog_fault` is high, each record programmed during packing has bit 0 inverted.
- R8: `wr_ready` and `busy` are never high together, and `busy` rises only right after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also blanks the flash model |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Engine can accept a write this cycle |
| wr_addr | input | 8 | Emulated EEPROM address |
| wr_data | input | 16 | Value to store |
| prog_fault | input | 1 | Flash model disturb: corrupts records programmed during packing |
| busy | output | 1 | Initialising, packing or erasing |
| err | output | 1 | Sticky packing verify failure |
| active_page | output | $clog2(NPAGES) | Index of the page currently receiving writes |
| rd_page | input | $clog2(NPAGES) | Lookup read page |
| rd_slot | input | $clog2(SLOTS) | Lookup read slot |
| rd_word | output | 24 | Flash word at rd_page/rd_slot |

## Verification
A wrong fill pointer shows on the read port straight after the offending write, either as a record in the wrong slot or as one that overwrote an earlier record. A stale entry in the address-seen map or a bad backward search does not show until compaction ends. At that point the new page holds a duplicate, a missing record or an old value, and the bench's full-array sweep catches it. A miscounted wrap shows only in the status word of a page that was packed into page 0, so the bench packs across several full rotations.

// File: rtl/eee_pkg.sv
package eee_pkg;
    localparam int EA_W   = 8;
    localparam int ED_W   = 16;
    localparam int WORD_W = EA_W + ED_W;

    localparam logic [1:0] PAGE_ACTIVE = 2'b10;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_SCAN,
        ST_FIND,
        ST_PROG,
        ST_VERIFY,
        ST_STAT,
        ST_ERASE,
        ST_FAULT
    } eng_state_t;

    function automatic logic [WORD_W-1:0] mk_status(input logic [ED_W-1:0] cnt);
        return {PAGE_ACTIVE, 6'b0, cnt};
    endfunction
endpackage

// File: rtl/eee_flash_array.sv
module eee_flash_array #(
    parameter int NPAGES = 2,
    parameter int SLOTS  = 512,
    parameter int WW     = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pg_en,
    input  logic [$clog2(NPAGES)-1:0] pg_page,
    input  logic [$clog2(SLOTS)-1:0]  pg_slot,
    input  logic [WW-1:0]             pg_word,
    input  logic                      er_en,
    input  logic [$clog2(NPAGES)-1:0] er_page,
    input  logic [$clog2(NPAGES)-1:0] ra_page,
    input  logic [$clog2(SLOTS)-1:0]  ra_slot,
    output logic [WW-1:0]             ra_word,
    input  logic [$clog2(NPAGES)-1:0] rb_page,
    input  logic [$clog2(SLOTS)-1:0]  rb_slot,
    output logic [WW-1:0]             rb_word
);
    localparam int PW    = $clog2(NPAGES);
    localparam int SIW   = $clog2(SLOTS);
    localparam int AW    = PW + SIW;
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    // Programming can only clear bits; erase returns a whole page to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            if (er_en)
                for (int s = 0; s < SLOTS; s++) mem[{er_page, SIW'(s)}] <= '1;
            if (pg_en)
                mem[{pg_page, pg_slot}] <= mem[{pg_page, pg_slot}] & pg_word;
        end
    end

    assign ra_word = mem[{ra_page, ra_slot}];
    assign rb_word = mem[{rb_page, rb_slot}];
endmodule

// File: rtl/eee_seen_map.sv
module eee_seen_map #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [(1<<AW)-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bits_q       <= '0;
        else if (clr)    bits_q       <= '0;
        else if (set)    bits_q[addr] <= 1'b1;
    end

    assign hit = bits_q[addr];
endmodule

// File: rtl/eee_write_engine.sv
module eee_write_engine
    import eee_pkg::*;
#(
    parameter int NPAGES = 2,
    parameter int SLOTS  = 512
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    output logic                      wr_ready,
    input  logic [EA_W-1:0]           wr_addr,
    input  logic [ED_W-1:0]           wr_data,
    input  logic                      prog_fault,
    output logic                      busy,
    output logic                      err,
    output logic [$clog2(NPAGES)-1:0] active_page,
    input  logic [$clog2(NPAGES)-1:0] rd_page,
    input  logic [$clog2(SLOTS)-1:0]  rd_slot,
    output logic [WORD_W-1:0]         rd_word
);
    localparam int PW  = $clog2(NPAGES);
    localparam int SIW = $clog2(SLOTS);
    localparam int CW  = SIW + 1;
    localparam logic [CW-1:0] SLOT_LAST = CW'(SLOTS - 1);
    localparam logic [CW-1:0] SLOT_END  = CW'(SLOTS);

    eng_state_t state, nxt;
    logic [PW-1:0]     act, dst;
    logic [CW-1:0]     ptr, src_i, dst_k, find_j;
    logic [EA_W-1:0]   cur_addr;
    logic [ED_W-1:0]   cur_data;

    logic              fl_pg_en, fl_er_en;
    logic [PW-1:0]     fl_pg_page, ra_page;
    logic [SIW-1:0]    fl_pg_slot, ra_slot;
    logic [WORD_W-1:0] fl_pg_word, ra_word;
    logic              seen_clr, seen_set, seen_hit;
    logic              accept, rec_match, copy_ok;
    logic [EA_W-1:0]   rec_addr;

    assign dst         = (act == PW'(NPAGES - 1)) ? '0 : act + 1'b1;
    assign accept      = wr_valid && wr_ready;
    assign rec_addr    = ra_word[WORD_W-1 -: EA_W];
    assign rec_match   = (rec_addr == cur_addr);
    assign copy_ok     = (ra_word == {cur_addr, cur_data});
    assign active_page = act;
    assign err         = (state == ST_FAULT);

    eee_flash_array #(.NPAGES(NPAGES), .SLOTS(SLOTS), .WW(WORD_W)) u_flash (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_en   (fl_pg_en),
        .pg_page (fl_pg_page),
        .pg_slot (fl_pg_slot),
        .pg_word (fl_pg_word),
        .er_en   (fl_er_en),
        .er_page (act),
        .ra_page (ra_page),
        .ra_slot (ra_slot),
        .ra_word (ra_word),
        .rb_page (rd_page),
        .rb_slot (rd_slot),
        .rb_word (rd_word)
    );

    eee_seen_map #(.AW(EA_W)) u_seen (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (seen_clr),
        .set   (seen_set),
        .addr  (rec_addr),
        .hit   (seen_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_INIT:   nxt = ST_IDLE;
            ST_IDLE:   if (accept && ptr == SLOT_LAST) nxt = ST_SCAN;
            ST_SCAN:   if (src_i == SLOT_END) nxt = ST_STAT;
                       else if (!seen_hit)    nxt = ST_FIND;
            ST_FIND:   if (rec_match) nxt = ST_PROG;
            ST_PROG:   nxt = ST_VERIFY;
            ST_VERIFY: nxt = copy_ok ? ST_SCAN : ST_FAULT;
            ST_STAT:   nxt = ST_ERASE;
            ST_ERASE:  nxt = ST_IDLE;
            ST_FAULT:  nxt = ST_FAULT;
            default:   nxt = ST_FAULT;
        endcase
    end

    // Outputs and flash/seen-map controls
    always_comb begin
        wr_ready   = 1'b0;
        busy       = 1'b1;
        fl_pg_en   = 1'b0;
        fl_pg_page = act;
        fl_pg_slot = '0;
        fl_pg_word = '1;
        fl_er_en   = 1'b0;
        ra_page    = act;
        ra_slot    = '0;
        seen_clr   = 1'b0;
        seen_set   = 1'b0;
        unique case (state)
            ST_INIT: begin
                fl_pg_en   = 1'b1;
                fl_pg_page = '0;
                fl_pg_word = mk_status('0);
            end
            ST_IDLE: begin
                busy       = 1'b0;
                wr_ready   = 1'b1;
                fl_pg_en   = wr_valid;
                fl_pg_slot = ptr[SIW-1:0];
                fl_pg_word = {wr_addr, wr_data};
                seen_clr   = wr_valid && (ptr == SLOT_LAST);
            end
            ST_SCAN: begin
                ra_slot  = src_i[SIW-1:0];
                seen_set = (src_i != SLOT_END) && !seen_hit;
            end
            ST_FIND: ra_slot = find_j[SIW-1:0];
            ST_PROG: begin
                fl_pg_en   = 1'b1;
                fl_pg_page = dst;
                fl_pg_slot = dst_k[SIW-1:0];
                fl_pg_word = {cur_addr, cur_data} ^ {{(WORD_W-1){1'b0}}, prog_fault};
            end
            ST_VERIFY: begin
                ra_page = dst;
                ra_slot = dst_k[SIW-1:0];
            end
            ST_STAT: begin
                fl_pg_en   = 1'b1;
                fl_pg_page = dst;
                fl_pg_word = mk_status(ra_word[ED_W-1:0] + ED_W'(dst == '0));
            end
            ST_ERASE: fl_er_en = 1'b1;
            ST_FAULT: busy = 1'b0;
            default: ;
        endcase
    end

    // Pointers and record holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act      <= '0;
            ptr      <= CW'(1);
            src_i    <= '0;
            dst_k    <= '0;
            find_j   <= '0;
            cur_addr <= '0;
            cur_data <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    ptr   <= ptr + 1'b1;
                    src_i <= CW'(1);
                    dst_k <= CW'(1);
                end
                ST_SCAN: if (src_i != SLOT_END) begin
                    if (seen_hit) src_i <= src_i + 1'b1;
                    else begin
                        cur_addr <= rec_addr;
                        find_j   <= SLOT_LAST;
                    end
                end
                ST_FIND: begin
                    if (rec_match) cur_data <= ra_word[ED_W-1:0];
                    else           find_j   <= find_j - 1'b1;
                end
                ST_VERIFY: if (copy_ok) begin
                    dst_k <= dst_k + 1'b1;
                    src_i <= src_i + 1'b1;
                end
                ST_ERASE: begin
                    act <= dst;
                    ptr <= dst_k;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eee_write_engine_chk.sv
module eee_write_engine_chk #(
    parameter int PW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          busy,
    input logic          err,
    input logic [PW-1:0] active_page
);
    assert_ready_busy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready && busy));

    assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_valid && wr_ready));

    assert_page_moves_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_page) |-> ($past(busy) && !busy));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_ready && !busy));

    assert_err_holds_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(active_page));
endmodule

bind eee_write_engine eee_write_engine_chk #(.PW($clog2(NPAGES))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .busy        (busy),
    .err         (err),
    .active_page (active_page)
);

// File: tb/sim_eee_write_engine.sv
`timescale 1ns/100ps
module sim_eee_write_engine;
    localparam int NP  = 2;
    localparam int SL  = 8;
    localparam int PW  = $clog2(NP);
    localparam int SIW = $clog2(SL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic prog_fault = 1'b0;
    logic [PW-1:0] rd_page = '0;
    logic [SIW-1:0] rd_slot = '0;
    logic wr_ready, busy, err;
    logic [PW-1:0] active_page;
    logic [23:0] rd_word;

    always #2.5 clk = ~clk;

    eee_write_engine #(.NPAGES(NP), .SLOTS(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_fault(prog_fault),
        .busy(busy), .err(err), .active_page(active_page),
        .rd_page(rd_page), .rd_slot(rd_slot), .rd_word(rd_word)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] mdl [NP][SL];
    int m_act = 0;
    int m_ptr = 1;
    int m_packs = 0;
    logic [7:0] pool [6] = '{8'h00, 8'h10, 8'h3C, 8'h7F, 8'hA5, 8'hFE};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] actv, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, actv, expv);
        end
    endtask

    task automatic cmp_page(input int p, input string req);
        bit ok = 1'b1;
        logic [23:0] a_w = '0, e_w = '0;
        int bad_s = 0;
        for (int s = 0; s < SL; s++) begin
            rd_page = PW'(p);
            rd_slot = SIW'(s);
            #0.5;
            if (ok && rd_word !== mdl[p][s]) begin
                ok = 1'b0; a_w = rd_word; e_w = mdl[p][s]; bad_s = s;
            end
        end
        chk(ok, req, $sformatf("page %0d slot %0d", p, bad_s), {8'h0, a_w}, {8'h0, e_w});
    endtask

    task automatic cmp_all(input string req);
        for (int p = 0; p < NP; p++) cmp_page(p, req);
    endtask

    task automatic model_pack();
        int dst, k, j;
        bit dup;
        logic [7:0] a;
        dst = (m_act + 1) % NP;
        k = 1;
        for (int i = 1; i < SL; i++) begin
            a = mdl[m_act][i][23:16];
            dup = 1'b0;
            for (int q = 1; q < i; q++) if (mdl[m_act][q][23:16] == a) dup = 1'b1;
            if (!dup) begin
                j = SL - 1;
                while (mdl[m_act][j][23:16] != a) j--;
                mdl[dst][k] = mdl[m_act][j];
                k++;
            end
        end
        mdl[dst][0] = {2'b10, 6'b0, mdl[m_act][0][15:0] + ((dst == 0) ? 16'd1 : 16'd0)};
        for (int s = 0; s < SL; s++) mdl[m_act][s] = 24'hFFFFFF;
        m_act = dst;
        m_ptr = k;
        m_packs++;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        bit last;
        string tag;
        @(negedge clk);
        while (!wr_ready && !err) @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        last = (m_ptr == SL - 1);
        @(negedge clk);
        wr_valid = 1'b0;
        mdl[m_act][m_ptr] = {a, d};
        m_ptr++;
        if (last) begin
            chk(busy && !wr_ready, "R3", "busy/ready after last slot",
                {30'b0, busy, wr_ready}, 32'h2);
            if (!prog_fault) model_pack();
        end
        while (!wr_ready && !err) @(negedge clk);
        if (!prog_fault) begin
            tag = last ? "R3" : (m_packs > 0 ? "R6" : "R2");
            cmp_all(tag);
            if (last) chk(active_page == PW'(m_act), "R5", "active page",
                          32'(active_page), 32'(m_act));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int src;
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < SL; s++) mdl[p][s] = 24'hFFFFFF;
        mdl[0][0] = 24'h800000;

        repeat (4) @(negedge clk);
        chk(busy && !wr_ready, "R1", "busy/ready in reset", {30'b0, busy, wr_ready}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ready && !busy, "R1", "ready after init", {30'b0, busy, wr_ready}, 32'h1);
        chk(active_page == '0, "R1", "active page after init", 32'(active_page), 32'h0);
        cmp_all("R1");

        // Four address patterns over a six-entry pool
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 14; n++) begin
                int idx;
                case (p)
                    0: idx = 0;
                    1: idx = n % 3;
                    2: idx = (n * 5) % 6;
                    default: idx = 5 - (n % 6);
                endcase
                do_write(pool[idx], 16'((p << 12) | (n << 4) | idx));
            end
        end

        // R4: count equals the number of packs that landed in page 0
        rd_page = PW'(m_act); rd_slot = '0;
        #0.5;
        chk(rd_word[15:0] == 16'(m_packs / NP) && rd_word[23:22] == 2'b10, "R4",
            "status word of active page", {8'h0, rd_word}, {8'h0, 2'b10, 6'b0, 16'(m_packs / NP)});
        chk(m_packs >= 2 * NP, "R4", "packs completed", 32'(m_packs), 32'(2 * NP));

        // R7: corrupt copies during the next compaction
        src = m_act;
        prog_fault = 1'b1;
        while (m_ptr < SL) do_write(8'h10, 16'hBEEF);
        repeat (2) @(negedge clk);
        chk(err === 1'b1, "R7", "err after bad verify", 32'(err), 32'h1);
        chk(!wr_ready && !busy, "R7", "ready/busy after fault", {30'b0, busy, wr_ready}, 32'h0);
        chk(active_page == PW'(src), "R7", "active page held", 32'(active_page), 32'(src));
        cmp_page(src, "R7");
        prog_fault = 1'b0;
        wr_valid = 1'b1; wr_addr = 8'h3C; wr_data = 16'h1234;
        repeat (10) @(negedge clk);
        wr_valid = 1'b0;
        @(negedge clk);
        chk(err === 1'b1, "R7", "err sticky", 32'(err), 32'h1);
        chk(active_page == PW'(src), "R7", "page after ignored write", 32'(active_page), 32'(src));
        cmp_page(src, "R7");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule